// File: doc/BRIEF.md
# Write-One Set/Clear GPIO Bank

This block is a memory-mapped I/O port with a parameterised number of pins (32 by default). Software changes pin levels and pin directions without reading them first. Four write-only registers act only on the pins whose data bit is 1. One sets output values high and one sets them low. One enables output drivers and one returns pins to high impedance. Any pin whose data bit is 0 keeps its state, so two software agents can each own a subset of pins without a read-modify-write race.

A fifth, read-only register returns the pin levels seen at the pads. Each level first passes through a two-stage synchronizer. The register bus is 32 bits wide: an address, a write strobe with write data, and a read strobe with registered read data. Bit n of every register always refers to pin n. The pad side provides an output-value vector, an output-enable vector and an input vector for external tri-state pad cells.

Top module: `gpio_sc_bank`

## Requirements
- R1: After reset, every output value is 0, every pin is tristated (output enable 0) and the read data is 0.
- R2: A write to offset 0x00 sets the output value to 1 for every pin whose data bit is 1. It changes no other output value and no output enable.
- R3: A write to offset 0x10 sets the output value to 0 for every pin whose data bit is 1. It changes no other output value and no output enable.
- R4: A write to offset 0x20 sets the output enable to 1 for every pin whose data bit is 1. It changes no other output enable and no output value.
- R5: A write to offset 0x30 sets the output enable to 0 for every pin whose data bit is 1. It changes no other output enable and no output value.
- R6: A write takes effect at the clock edge where its strobe is sampled, and the new state shows on the pad outputs in the cycle after the strobe.
- R7: A read strobe at offset 0x40 returns the synchronized pin levels on the read data in the cycle after the strobe, with bit n holding the level of pin n.
- R8: A change on the pin inputs reaches the value read at offset 0x40 after two clock edges. A read whose data is captured at the first or second edge after the change returns the old level. A read captured at the third edge returns the new level.
- R9: Read data is 0 in every cycle that does not follow a read strobe at offset 0x40. This includes reads of offsets 0x00, 0x10, 0x20 and 0x30 and of unmapped offsets.
- R10: A write to any offset other than 0x00, 0x10, 0x20 and 0x30 changes no output value and no output enable. This includes a write to offset 0x40.
- R11: A pin keeps its stored output value while it is tristated, and it drives that value again once its output enable is turned back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data, bit n for pin n |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid in the cycle after the read strobe |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin, 1 drives the pad |
| pad_in | input | 32 | Level seen at each pad |

## Verification
The assertions check four rules on every cycle. Each set, clear, enable and tristate write moves exactly the masked bits in the intended direction and leaves the other vector alone. A cycle without a decoded write leaves both vectors unchanged. Read data stays zero unless the previous cycle carried a read of the input offset. The synchronizer output always equals the pad level from two edges earlier. Three things show only in the bench scenarios: the exact cycle in which a pad change first appears in read data, a stored value surviving a tristate and enable round trip, and the combined effect of a sequence of overlapping masks.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;

    // Register offsets (byte addresses on the register bus)
    localparam int unsigned OFS_SET  = 32'h00;
    localparam int unsigned OFS_CLR  = 32'h10;
    localparam int unsigned OFS_DRV  = 32'h20;
    localparam int unsigned OFS_HIZ  = 32'h30;
    localparam int unsigned OFS_PINS = 32'h40;

    // One-hot decoded register strobes
    typedef struct packed {
        logic set;
        logic clr;
        logic drv;
        logic hiz;
        logic rd_pins;
    } bank_strobe_t;

endpackage

// File: rtl/gpio_sc_decode.sv
module gpio_sc_decode
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bank_strobe_t      stb
);

    always_comb begin
        stb         = '0;
        stb.set     = wr && (addr == ADDR_W'(OFS_SET));
        stb.clr     = wr && (addr == ADDR_W'(OFS_CLR));
        stb.drv     = wr && (addr == ADDR_W'(OFS_DRV));
        stb.hiz     = wr && (addr == ADDR_W'(OFS_HIZ));
        stb.rd_pins = rd && (addr == ADDR_W'(OFS_PINS));
    end

endmodule

// File: rtl/gpio_sc_pin_state.sv
module gpio_sc_pin_state
    import gpio_sc_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  bank_strobe_t    stb,
    input  logic [PINS-1:0] wdata,
    output logic [PINS-1:0] out_val,
    output logic [PINS-1:0] out_en
);

    typedef struct packed {
        logic [PINS-1:0] val;
        logic [PINS-1:0] en;
    } pin_state_t;

    pin_state_t st_d, st_q;
    logic [PINS-1:0] val_nx, en_nx;

    // Per-pin next state: a 1 in the mask moves the pin, a 0 holds it
    for (genvar g = 0; g < PINS; g++) begin : g_pin
        assign val_nx[g] = (stb.set && wdata[g]) ? 1'b1 :
                           (stb.clr && wdata[g]) ? 1'b0 : st_q.val[g];
        assign en_nx[g]  = (stb.drv && wdata[g]) ? 1'b1 :
                           (stb.hiz && wdata[g]) ? 1'b0 : st_q.en[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.val = val_nx;
        st_d.en  = en_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_val = st_q.val;
    assign out_en  = st_q.en;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stb.set |=> ((out_val & $past(wdata)) == $past(wdata)) && $stable(out_en));
    p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb.clr |=> ((out_val & $past(wdata)) == '0) && $stable(out_en));
    p_drv_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb.drv |=> ((out_en & $past(wdata)) == $past(wdata)) && $stable(out_val));
    p_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stb.hiz |=> ((out_en & $past(wdata)) == '0) && $stable(out_val));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stb.set || stb.clr || stb.drv || stb.hiz) |=> $stable(out_val) && $stable(out_en));

endmodule

// File: rtl/gpio_sc_input_sync.sv
module gpio_sc_input_sync #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pins_async,
    output logic [PINS-1:0] pins_sync
);

    typedef struct packed {
        logic [PINS-1:0] meta;
        logic [PINS-1:0] stable;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d        = sy_q;
        sy_d.meta   = pins_async;
        sy_d.stable = sy_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign pins_sync = sy_q.stable;

    // Checker-only warm-up count: the two-edge relation holds once both stages have loaded
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    p_two_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (pins_sync == $past(pins_async, 2)));

endmodule

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
    import gpio_sc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PINS   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_rd,
    output logic [PINS-1:0]   bus_rdata,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    input  logic [PINS-1:0]   pad_in
);

    bank_strobe_t    stb;
    logic [PINS-1:0] pins_sync;

    typedef struct packed {
        logic [PINS-1:0] rdata;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    gpio_sc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .stb  (stb)
    );

    gpio_sc_pin_state #(.PINS(PINS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .stb     (stb),
        .wdata   (bus_wdata),
        .out_val (pad_out),
        .out_en  (pad_oe)
    );

    gpio_sc_input_sync #(.PINS(PINS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_async (pad_in),
        .pins_sync  (pins_sync)
    );

    // Read path: only the pin-level register returns data; all else reads 0
    always_comb begin
        rd_d       = '0;
        if (stb.rd_pins) rd_d.rdata = pins_sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q.rdata;

    p_rdata_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && (bus_addr == ADDR_W'(OFS_PINS))) |=> (bus_rdata == '0));

endmodule

// File: tb/gpio_sc_bank_test.sv
module gpio_sc_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] pad_in = '0;

    always #5 clk = ~clk;

    gpio_sc_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
    );

    typedef struct {
        string       req;
        logic [31:0] out;
        logic [31:0] oe;
        logic [31:0] rd;
    } exp_t;

    exp_t        sb[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;
    logic [31:0] m_out = '0;
    logic [31:0] m_oe  = '0;

    task automatic push(input string req, input logic [31:0] rd);
        exp_t e;
        e.req = req; e.out = m_out; e.oe = m_oe; e.rd = rd;
        sb.push_back(e);
    endtask

    // Write: strobe in one cycle, expect the new state at the next negedge (R6)
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        case (a)
            8'h00: m_out = m_out | d;
            8'h10: m_out = m_out & ~d;
            8'h20: m_oe  = m_oe | d;
            8'h30: m_oe  = m_oe & ~d;
            default: ;
        endcase
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        push(req, 32'h0);
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        push(req, exp);
    endtask

    task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops every expected item shortly after each negedge
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            cmp(e.req, "pad_out",   pad_out,   e.out);
            cmp(e.req, "pad_oe",    pad_oe,    e.oe);
            cmp(e.req, "bus_rdata", bus_rdata, e.rd);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push("R1 reset", 32'h0);

        wr(8'h00, 32'hA5A5_0001, "R2 set mask");
        wr(8'h00, 32'h8000_F000, "R2 set more incl pin 31");
        wr(8'h10, 32'h0000_0001, "R3 clear pin 0");
        wr(8'h10, 32'h0F0F_0000, "R3 clear overlap");
        wr(8'h20, 32'hFFFF_0000, "R4 enable upper half");
        wr(8'h20, 32'h0000_0001, "R4 enable pin 0");
        wr(8'h30, 32'h8000_0001, "R5 tristate pins 31 and 0");
        wr(8'h00, 32'h0000_0000, "R2 zero mask no change");

        // Stored value survives tristate and is driven again
        wr(8'h30, 32'hFFFF_FFFF, "R11 tristate all");
        wr(8'h20, 32'h8000_F000, "R11 re-enable keeps values");

        // Unmapped writes ignored
        wr(8'h04, 32'hFFFF_FFFF, "R10 write 0x04");
        wr(8'h40, 32'hFFFF_FFFF, "R10 write 0x40");
        wr(8'h50, 32'h0000_0000, "R10 write 0x50");
        wr(8'hF0, 32'hFFFF_FFFF, "R10 write 0xF0");

        // Write-only and unmapped reads return 0
        rd(8'h00, 32'h0, "R9 read 0x00");
        rd(8'h10, 32'h0, "R9 read 0x10");
        rd(8'h20, 32'h0, "R9 read 0x20");
        rd(8'h30, 32'h0, "R9 read 0x30");
        rd(8'h44, 32'h0, "R9 read 0x44");

        // Input reads with stable pads
        pad_in = 32'h8000_0001;
        repeat (3) @(negedge clk);
        rd(8'h40, 32'h8000_0001, "R7 pins 31 and 0");
        pad_in = 32'h1234_5678;
        repeat (3) @(negedge clk);
        rd(8'h40, 32'h1234_5678, "R7 pattern");
        @(negedge clk);
        push("R9 idle after read", 32'h0);

        // Synchronizer latency: change and read back-to-back
        @(negedge clk);
        pad_in = 32'hCAFE_0F0F; bus_addr = 8'h40; bus_rd = 1'b1;
        @(negedge clk); push("R8 first edge old", 32'h1234_5678);
        @(negedge clk); push("R8 second edge old", 32'h1234_5678);
        @(negedge clk); push("R8 third edge new", 32'hCAFE_0F0F);
        bus_rd = 1'b0;

        // Clear everything, boundary mask
        wr(8'h10, 32'hFFFF_FFFF, "R3 clear all");
        wr(8'h30, 32'hFFFF_FFFF, "R5 tristate all");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule